// File: doc/BRIEF.md
# IO Port Bus Adapter

This block sits between a processor core and a 64K-port peripheral bus. The core hands it one port transfer at a time: a 16-bit port address, a read or write flag, an access size (byte, halfword or word) and 32 bits of write data. The adapter drives the port address, the write data and a 3-bit thermometer-coded enable on the write or the read side. For reads it samples the peripheral's read bus, clears the bits above the requested size and returns the value to the core with a one-cycle completion pulse.

No alignment rule applies and no byte lanes are steered. Any port address is legal for any size, data always sits on the low bits, and the enable code tells the peripheral how wide the access is. A busy input from the peripheral side stretches the transfer: while it is high the bus values stay frozen and no completion is given.

Top module: `io_port_adapter`

## Requirements
- R1: After reset both enable buses are 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A request accepted at a clock edge (req_valid and req_ready high, legal size) drives `io_addr` and one enable bus in the following cycle: `io_wr_en` when `req_write` is 1, `io_rd_en` when it is 0; the other enable bus stays 0.
- R3: The enable code follows `req_size`: 0 (byte) gives 3'b001, 1 (halfword) gives 3'b011, 2 (word) gives 3'b111. No other nonzero code ever appears.
- R4: `io_wdata` carries `req_wdata` right-justified with bits above the size cleared: bits 7:0 kept for a byte, 15:0 for a halfword, 31:0 for a word.
- R5: Every port address, aligned or not, is passed unchanged to `io_addr` for every size.
- R6: While an enable is asserted and `io_busy` is 1, `io_addr`, `io_wdata` and both enable buses hold their values across the edge and `rsp_valid` stays 0.
- R7: An enable is asserted in a cycle where `io_busy` is 0 for exactly that one cycle; in the next cycle both enables are 0 and `rsp_valid` is 1 for one cycle.
- R8: For a read, `io_rdata` sampled at the edge ending the enable cycle with `io_busy` 0 is returned on `rsp_rdata` together with `rsp_valid`, with bits above the size zeroed (31:8 for a byte, 31:16 for a halfword).
- R9: A request with `req_size` 3 is reserved: it is not accepted, no enable is driven and no `rsp_valid` follows.
- R10: While a transfer is pending `req_ready` is 0 and any request presented is ignored; the held bus values do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core presents a port transfer |
| req_write | input | 1 | 1 for write, 0 for read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_addr | input | 16 | Port address |
| req_wdata | input | 32 | Write data, right-justified |
| req_ready | output | 1 | Adapter can take a request this cycle |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Zero-extended read data |
| io_addr | output | 16 | Port address on the peripheral bus |
| io_wdata | output | 32 | Write data on the peripheral bus |
| io_wr_en | output | 3 | Thermometer write enable |
| io_rd_en | output | 3 | Thermometer read enable |
| io_rdata | input | 32 | Read data from the peripherals |
| io_busy | input | 1 | Peripheral stall |

## Verification
The bus values and the enable code are due one edge after acceptance, so the bench checks them at the falling edge that follows it; each busy cycle then adds exactly one edge, checked at its own falling edge for frozen values and absent completion. The completion pulse and the zero-extended read word are due one edge after the first enable cycle with busy low, and the bench samples them at the next falling edge, where it also confirms the enables have dropped. Reserved-size and while-pending requests are checked over the same edges to show that nothing moves on the bus and no completion arrives.

// File: rtl/io_port_adapter.sv
module io_port_adapter #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] io_addr,
  output logic [DATA_W-1:0] io_wdata,
  output logic [2:0]        io_wr_en,
  output logic [2:0]        io_rd_en,
  input  logic [DATA_W-1:0] io_rdata,
  input  logic              io_busy
);

  localparam int HI_W = DATA_W - 16;

  function automatic logic [2:0] size_code(input logic [1:0] s);
    case (s)
      2'd0:    return 3'b001;
      2'd1:    return 3'b011;
      2'd2:    return 3'b111;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] trim(input logic [DATA_W-1:0] d, input logic [2:0] c);
    logic [DATA_W-1:0] m;
    m = {{HI_W{c[2]}}, {8{c[1]}}, {8{c[0]}}};
    return d & m;
  endfunction

  logic              active;
  logic              is_wr;
  logic [2:0]        code_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rsp_q;
  logic              rsp_v;
  logic [2:0]        req_code;
  logic              accept;

  assign req_code = size_code(req_size);
  assign accept   = req_valid && !active && (req_code != 3'b000);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      is_wr   <= 1'b0;
      code_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rsp_q   <= '0;
      rsp_v   <= 1'b0;
    end else begin
      rsp_v <= 1'b0;
      if (accept) begin
        active  <= 1'b1;
        is_wr   <= req_write;
        code_q  <= req_code;
        addr_q  <= req_addr;
        wdata_q <= trim(req_wdata, req_code);
      end else if (active && !io_busy) begin
        active <= 1'b0;
        rsp_v  <= 1'b1;
        rsp_q  <= is_wr ? '0 : trim(io_rdata, code_q);
      end
    end
  end

  assign req_ready = !active;
  assign rsp_valid = rsp_v;
  assign rsp_rdata = rsp_q;
  assign io_addr   = addr_q;
  assign io_wdata  = wdata_q;
  assign io_wr_en  = (active && is_wr)  ? code_q : 3'b000;
  assign io_rd_en  = (active && !is_wr) ? code_q : 3'b000;

endmodule

// File: rtl/io_port_adapter_chk.sv
module io_port_adapter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [1:0]  req_size,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic [31:0] rsp_rdata,
  input logic [15:0] io_addr,
  input logic [31:0] io_wdata,
  input logic [2:0]  io_wr_en,
  input logic [2:0]  io_rd_en,
  input logic        io_busy
);

  logic en_on;
  assign en_on = (io_wr_en != 3'b000) || (io_rd_en != 3'b000);

  assert_one_side_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !((io_wr_en != 3'b000) && (io_rd_en != 3'b000)));

  assert_legal_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr_en inside {3'b000, 3'b001, 3'b011, 3'b111}) &&
    (io_rd_en inside {3'b000, 3'b001, 3'b011, 3'b111}));

  assert_accept_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_size != 2'd3) |=> en_on);

  assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_on && io_busy) |=> ($stable(io_addr) && $stable(io_wdata) &&
                            $stable(io_wr_en) && $stable(io_rd_en) && !rsp_valid));

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_on && !io_busy) |=> (!en_on && rsp_valid));

  assert_byte_zeroext_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(io_rd_en) == 3'b001) |-> (rsp_rdata[31:8] == 24'd0));

  assert_half_zeroext_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(io_rd_en) == 3'b011) |-> (rsp_rdata[31:16] == 16'd0));

  assert_reserved_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_size == 2'd3) |=> (!en_on && req_ready));

  assert_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    en_on |-> !req_ready);

endmodule

bind io_port_adapter io_port_adapter_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_size  (req_size),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .io_addr   (io_addr),
  .io_wdata  (io_wdata),
  .io_wr_en  (io_wr_en),
  .io_rd_en  (io_rd_en),
  .io_busy   (io_busy)
);

// File: tb/io_port_adapter_bench.sv
`timescale 1ns/1ps
module io_port_adapter_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [15:0] io_addr;
  logic [31:0] io_wdata;
  logic [2:0]  io_wr_en;
  logic [2:0]  io_rd_en;
  logic [31:0] io_rdata;
  logic        io_busy = 1'b0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  assign io_rdata = {io_addr ^ 16'hA5C3, io_addr};

  io_port_adapter u_io_port_adapter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_wr_en(io_wr_en),
    .io_rd_en(io_rd_en), .io_rdata(io_rdata), .io_busy(io_busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] keep(input logic [31:0] d, input int sz);
    if (sz == 0) return {24'd0, d[7:0]};
    if (sz == 1) return {16'd0, d[15:0]};
    return d;
  endfunction

  function automatic logic [2:0] ecode(input int sz);
    return (sz == 0) ? 3'b001 : (sz == 1) ? 3'b011 : 3'b111;
  endfunction

  task automatic xfer(input logic wr, input int sz, input logic [15:0] a,
                      input logic [31:0] wd, input int nb);
    logic [31:0] exp_w;
    exp_w = keep(wd, sz);
    @(negedge clk);
    chk("R10 ready before request", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_write = wr; req_size = sz[1:0]; req_addr = a; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    io_busy = (nb > 0);
    chk("R5 io_addr", {16'd0, io_addr}, {16'd0, a});
    chk("R2 R3 write enable", {29'd0, io_wr_en}, wr ? {29'd0, ecode(sz)} : 32'd0);
    chk("R2 R3 read enable", {29'd0, io_rd_en}, wr ? 32'd0 : {29'd0, ecode(sz)});
    if (wr) chk("R4 io_wdata", io_wdata, exp_w);
    chk("R10 ready while pending", {31'd0, req_ready}, 32'd0);
    if (nb > 0) begin
      req_valid = 1'b1; req_write = ~wr; req_size = 2'd2; req_addr = ~a; req_wdata = ~wd;
    end
    for (int k = 0; k < nb; k++) begin
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R6 R10 addr held", {16'd0, io_addr}, {16'd0, a});
      chk("R6 enables held", {26'd0, io_wr_en, io_rd_en},
          wr ? {26'd0, ecode(sz), 3'b000} : {26'd0, 3'b000, ecode(sz)});
      if (wr) chk("R6 wdata held", io_wdata, exp_w);
      chk("R6 no completion", {31'd0, rsp_valid}, 32'd0);
      io_busy = (k + 1 < nb);
    end
    @(posedge clk);
    @(negedge clk);
    chk("R7 enables dropped", {26'd0, io_wr_en, io_rd_en}, 32'd0);
    chk("R7 completion pulse", {31'd0, rsp_valid}, 32'd1);
    if (!wr) chk("R8 read data", rsp_rdata, keep({a ^ 16'hA5C3, a}, sz));
    @(posedge clk);
    @(negedge clk);
    chk("R7 pulse single", {31'd0, rsp_valid}, 32'd0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] addrs [6];
    addrs[0] = 16'h0000; addrs[1] = 16'h0001; addrs[2] = 16'h0002;
    addrs[3] = 16'h0003; addrs[4] = 16'h7FFD; addrs[5] = 16'hFFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 wr_en reset", {29'd0, io_wr_en}, 32'd0);
    chk("R1 rd_en reset", {29'd0, io_rd_en}, 32'd0);
    chk("R1 rsp_valid reset", {31'd0, rsp_valid}, 32'd0);
    chk("R1 ready reset", {31'd0, req_ready}, 32'd1);
    rst_n = 1'b1;
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 3; s++)
        for (int i = 0; i < 6; i++)
          for (int b = 0; b < 3; b++)
            xfer(w[0], s, addrs[i], 32'h8C4F_1E2D ^ {addrs[i], addrs[i]}, b);
    // R9 reserved size
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_size = 2'd3; req_addr = 16'h1234; req_wdata = 32'hFFFF_FFFF;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 no enable", {26'd0, io_wr_en, io_rd_en}, 32'd0);
    chk("R9 still ready", {31'd0, req_ready}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    chk("R9 no completion", {31'd0, rsp_valid}, 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule